// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block sits on the programmer side of a two-wire serial programming link and runs from a fast system clock. It produces the serial clock and the bidirectional data line for a protocol in which every instruction is a 4-bit command followed by a 16-bit operand, sent least significant bit first. Host logic hands it one request at a time over a valid/ready handshake. The sequencer then produces the whole frame, including the idle gaps between fields, the bus turnaround of a read, the externally timed programming pulse with its discharge interval, and the self-timed erase wait. It raises a one-cycle done pulse when the frame has finished.

Four kinds of request exist. A write sends a command and its 16-bit payload. A read sends a command and 8 operand bits, releases the data line, clocks in one byte and returns it. A program request sends its frame and then a trailing all-zero no-op whose fourth clock is stretched high for the programming time. An erase request sends its frame and then a no-op whose fourth clock is followed by a long low wait with the data line held low. Every interval is given in nanoseconds and converted to system-clock cycles from a clock-frequency parameter. The high and low half periods are set from the slowest supply the link must serve.

Top module: `sps_host_seq`

## Requirements
- R1: After reset the serial clock and data outputs are low, the data-enable output is high, ready is high and done is low.
- R2: Frame bits are placed on the data line only together with a rising serial clock edge and stay stable until the next rise. The 4 command bits go first, then the operand bits, each field least significant bit first.
- R3: Every ordinary serial clock bit is high for exactly HALF cycles and then low for at least HALF cycles.
- R4: A write request (kind 0) sends 4 command bits, holds the clock low for GAP extra cycles, sends 16 payload bits and then holds low for GAP more cycles. The request lasts 40*HALF + 2*GAP cycles from acceptance to done.
- R5: A read request (kind 1) sends 4 command bits, a GAP, and then payload bits 7..0 least significant first. It then holds the clock low for TURN cycles, gives 8 receive clocks, samples the input data line at each of their falling edges into the result byte least significant bit first, ends with a GAP, and presents the byte with done. Total: 40*HALF + TURN + 2*GAP cycles.
- R6: The data-enable output is low for exactly TURN + 16*HALF cycles in a read (the turnaround and the 8 receive clocks) and is never low in any other request or while ready is high.
- R7: A program request (kind 2) sends its frame, a GAP, and then an all-zero no-op. The fourth clock of that no-op is held high for PMEM cycles when the long-hold input is 0, or PCFG cycles when it is 1, then low for DISCH cycles, followed by 16 zero bits and a GAP. Total: 78*HALF + 3*GAP + hold + DISCH cycles.
- R8: An erase request (kind 3) sends its frame, a GAP, and four zero command clocks. After the fourth falling edge it holds the clock and data low for ERASE cycles, then sends 16 zero bits and a GAP. Total: 79*HALF + 3*GAP + ERASE cycles.
- R9: A request is taken only in a cycle with both valid and ready high. Ready then stays low until the frame ends. Done is a one-cycle pulse in the first cycle that ready is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_kind | input | 2 | 0 write, 1 read, 2 program, 3 erase |
| req_cmd | input | 4 | 4-bit command field |
| req_payload | input | 16 | Operand; a read sends only bits 7..0 |
| req_long | input | 1 | Program request uses the long hold |
| pgc | output | 1 | Serial clock to the target |
| pgd_out | output | 1 | Serial data driven to the target |
| pgd_oe | output | 1 | Drive enable for the data pin, low while receiving |
| pgd_in | input | 1 | Serial data returned by the target |
| rsp_done | output | 1 | One-cycle pulse at the end of each request |
| rsp_data | output | 8 | Byte received by the last read |

## Verification
Each result is due a fixed number of system cycles after the acceptance edge. The count follows from the phase lengths: 40*HALF + 2*GAP for a write, plus TURN for a read, and the longer sums given for program and erase. The bench counts the busy cycles with a falling-edge monitor and compares the count with that sum. It also measures the longest high and low runs of the serial clock, which fall on the programming hold, the discharge and the erase wait, and it counts the cycles the data pin is released. The target's read data is driven at the first falling system edge after each receive clock rises, so it is stable at the sequencer's sampling point. The returned byte and the done pulse are checked at the falling edge that follows the done edge.

// File: rtl/sps_pkg.sv
package sps_pkg;

    localparam int CMD_BITS = 4;
    localparam int OPD_BITS = 16;
    localparam int RD_BITS  = 8;
    localparam int IDX_W    = $clog2(OPD_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HI,
        ST_LO,
        ST_GAP,
        ST_TURN
    } phase_e;

    typedef enum logic [2:0] {
        SG_CMD,
        SG_OPD,
        SG_NCMD,
        SG_NOPD,
        SG_RX
    } seg_e;

    typedef enum logic [1:0] {
        K_WRITE = 2'd0,
        K_READ  = 2'd1,
        K_PROG  = 2'd2,
        K_ERASE = 2'd3
    } kind_e;

    // Round a duration up to whole system cycles, never below one.
    function automatic longint unsigned ns_to_cyc(longint unsigned ns, longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 64'd1 : c;
    endfunction

endpackage

// File: rtl/sps_phase_len.sv
module sps_phase_len
    import sps_pkg::*;
#(
    parameter int              TW   = 8,
    parameter longint unsigned H_C  = 1,
    parameter longint unsigned G_C  = 1,
    parameter longint unsigned T_C  = 1,
    parameter longint unsigned PM_C = 1,
    parameter longint unsigned PC_C = 1,
    parameter longint unsigned D_C  = 1,
    parameter longint unsigned E_C  = 1
) (
    input  phase_e              phase,
    input  seg_e                seg,
    input  logic [IDX_W-1:0]    idx,
    input  kind_e               kind,
    input  logic                lng,
    output logic [TW-1:0]       lim
);
    localparam logic [TW-1:0] L_H  = TW'(H_C - 1);
    localparam logic [TW-1:0] L_G  = TW'(G_C - 1);
    localparam logic [TW-1:0] L_T  = TW'(T_C - 1);
    localparam logic [TW-1:0] L_PM = TW'(PM_C - 1);
    localparam logic [TW-1:0] L_PC = TW'(PC_C - 1);
    localparam logic [TW-1:0] L_D  = TW'(D_C - 1);
    localparam logic [TW-1:0] L_E  = TW'(E_C - 1);

    logic fourth_nop;

    always_comb begin
        fourth_nop = (seg == SG_NCMD) && (idx == IDX_W'(CMD_BITS - 1));
        unique case (phase)
            ST_HI: begin
                if (fourth_nop && kind == K_PROG) lim = lng ? L_PC : L_PM;
                else                              lim = L_H;
            end
            ST_LO: begin
                if (fourth_nop && kind == K_PROG)       lim = L_D;
                else if (fourth_nop && kind == K_ERASE) lim = L_E;
                else                                    lim = L_H;
            end
            ST_GAP:  lim = L_G;
            ST_TURN: lim = L_T;
            default: lim = '0;
        endcase
    end
endmodule

// File: rtl/sps_pin_drive.sv
module sps_pin_drive
    import sps_pkg::*;
(
    input  phase_e               phase,
    input  seg_e                 seg,
    input  logic [IDX_W-1:0]     idx,
    input  logic [CMD_BITS-1:0]  cmd,
    input  logic [OPD_BITS-1:0]  pay,
    output logic                 clk_o,
    output logic                 dat_o,
    output logic                 oe_o
);
    always_comb begin
        clk_o = (phase == ST_HI);
        unique case (seg)
            SG_CMD:  dat_o = cmd[idx[$clog2(CMD_BITS)-1:0]];
            SG_OPD:  dat_o = pay[idx];
            default: dat_o = 1'b0;
        endcase
        oe_o = !((phase == ST_TURN) ||
                 (seg == SG_RX && (phase == ST_HI || phase == ST_LO)));
    end
endmodule

// File: rtl/sps_rx_capture.sv
module sps_rx_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         cap,
    input  logic         din,
    output logic [W-1:0] data
);
    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (clr)      data_d = '0;
        else if (cap) data_d = {din, data_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data = data_q;
endmodule

// File: rtl/sps_host_seq.sv
module sps_host_seq
    import sps_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned HALF_NS     = 500,
    parameter int unsigned GAP_NS      = 40,
    parameter int unsigned TURN_NS     = 20,
    parameter int unsigned PROG_MEM_NS = 1_000_000,
    parameter int unsigned PROG_CFG_NS = 5_000_000,
    parameter int unsigned DISCH_NS    = 100_000,
    parameter int unsigned ERASE_NS    = 5_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic [3:0]  req_cmd,
    input  logic [15:0] req_payload,
    input  logic        req_long,
    output logic        pgc,
    output logic        pgd_out,
    output logic        pgd_oe,
    input  logic        pgd_in,
    output logic        rsp_done,
    output logic [7:0]  rsp_data
);
    localparam longint unsigned H_C  = ns_to_cyc(HALF_NS, CLK_HZ);
    localparam longint unsigned G_C  = ns_to_cyc(GAP_NS, CLK_HZ);
    localparam longint unsigned T_C  = ns_to_cyc(TURN_NS, CLK_HZ);
    localparam longint unsigned PM_C = ns_to_cyc(PROG_MEM_NS, CLK_HZ);
    localparam longint unsigned PC_C = ns_to_cyc(PROG_CFG_NS, CLK_HZ);
    localparam longint unsigned D_C  = ns_to_cyc(DISCH_NS, CLK_HZ);
    localparam longint unsigned E_C  = ns_to_cyc(ERASE_NS, CLK_HZ);
    localparam longint unsigned M1   = (H_C > G_C) ? H_C : G_C;
    localparam longint unsigned M2   = (M1 > T_C) ? M1 : T_C;
    localparam longint unsigned M3   = (M2 > PM_C) ? M2 : PM_C;
    localparam longint unsigned M4   = (M3 > PC_C) ? M3 : PC_C;
    localparam longint unsigned M5   = (M4 > D_C) ? M4 : D_C;
    localparam longint unsigned MAXC = (M5 > E_C) ? M5 : E_C;
    localparam int TW = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e                st;
        seg_e                  seg;
        kind_e                 kind;
        logic                  lng;
        logic [CMD_BITS-1:0]   cmd;
        logic [OPD_BITS-1:0]   pay;
        logic [IDX_W-1:0]      idx;
        logic [TW-1:0]         tmr;
        logic                  done;
    } seq_t;

    seq_t              d, q;
    logic [TW-1:0]     lim;
    logic              end_ph;
    logic [IDX_W-1:0]  last_opd;
    logic              rx_clr, rx_cap;

    sps_phase_len #(
        .TW(TW), .H_C(H_C), .G_C(G_C), .T_C(T_C),
        .PM_C(PM_C), .PC_C(PC_C), .D_C(D_C), .E_C(E_C)
    ) u_len (
        .phase(q.st), .seg(q.seg), .idx(q.idx),
        .kind(q.kind), .lng(q.lng), .lim(lim)
    );

    sps_pin_drive u_pins (
        .phase(q.st), .seg(q.seg), .idx(q.idx), .cmd(q.cmd), .pay(q.pay),
        .clk_o(pgc), .dat_o(pgd_out), .oe_o(pgd_oe)
    );

    sps_rx_capture #(.W(RD_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .cap(rx_cap),
        .din(pgd_in), .data(rsp_data)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.tmr    = q.tmr + 1'b1;
        end_ph   = (q.tmr == lim);
        last_opd = (q.kind == K_READ) ? IDX_W'(RD_BITS - 1) : IDX_W'(OPD_BITS - 1);
        rx_clr   = (q.st == ST_IDLE) && req_valid;
        rx_cap   = (q.st == ST_HI) && (q.seg == SG_RX) && end_ph;

        unique case (q.st)
            ST_IDLE: begin
                d.tmr = '0;
                if (req_valid) begin
                    d.kind = kind_e'(req_kind);
                    d.lng  = req_long;
                    d.cmd  = req_cmd;
                    d.pay  = req_payload;
                    d.st   = ST_HI;
                    d.seg  = SG_CMD;
                    d.idx  = '0;
                end
            end
            ST_HI: begin
                if (end_ph) begin
                    d.st  = ST_LO;
                    d.tmr = '0;
                end
            end
            ST_LO: begin
                if (end_ph) begin
                    d.tmr = '0;
                    d.st  = ST_HI;
                    d.idx = q.idx + 1'b1;
                    unique case (q.seg)
                        SG_CMD: begin
                            if (q.idx == IDX_W'(CMD_BITS - 1)) begin
                                d.st  = ST_GAP;
                                d.idx = q.idx;
                            end
                        end
                        SG_OPD: begin
                            if (q.idx == last_opd) begin
                                d.st  = (q.kind == K_READ) ? ST_TURN : ST_GAP;
                                d.idx = q.idx;
                            end
                        end
                        SG_NCMD: begin
                            if (q.idx == IDX_W'(CMD_BITS - 1)) begin
                                d.seg = SG_NOPD;
                                d.idx = '0;
                            end
                        end
                        SG_NOPD: begin
                            if (q.idx == IDX_W'(OPD_BITS - 1)) begin
                                d.st  = ST_GAP;
                                d.idx = q.idx;
                            end
                        end
                        default: begin
                            if (q.idx == IDX_W'(RD_BITS - 1)) begin
                                d.st  = ST_GAP;
                                d.idx = q.idx;
                            end
                        end
                    endcase
                end
            end
            ST_GAP: begin
                if (end_ph) begin
                    d.tmr = '0;
                    if (q.seg == SG_CMD) begin
                        d.st  = ST_HI;
                        d.seg = SG_OPD;
                        d.idx = '0;
                    end else if (q.seg == SG_OPD &&
                                 (q.kind == K_PROG || q.kind == K_ERASE)) begin
                        d.st  = ST_HI;
                        d.seg = SG_NCMD;
                        d.idx = '0;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (end_ph) begin
                    d.tmr = '0;
                    d.st  = ST_HI;
                    d.seg = SG_RX;
                    d.idx = '0;
                end
            end
            default: begin
                d.st  = ST_IDLE;
                d.tmr = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.seg  <= SG_NCMD;
            q.kind <= K_WRITE;
            q.lng  <= 1'b0;
            q.cmd  <= '0;
            q.pay  <= '0;
            q.idx  <= '0;
            q.tmr  <= '0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_done  = q.done;
endmodule

// File: rtl/sps_host_seq_chk.sv
module sps_host_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic pgc,
    input logic pgd_out,
    input logic pgd_oe,
    input logic rsp_done
);
    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    // R2
    data_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pgd_out) |-> $rose(pgc));

    // R6
    release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pgd_oe |-> !req_ready && !rsp_done);

    // R6
    release_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pgd_oe) |-> !pgc);
endmodule

bind sps_host_seq sps_host_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .pgc(pgc), .pgd_out(pgd_out), .pgd_oe(pgd_oe), .rsp_done(rsp_done)
);

// File: tb/sps_host_seq_bench.sv
`timescale 1ns/1ps
module sps_host_seq_bench;
    // Cycle counts at 200 MHz for the overrides below.
    localparam int EH  = 4;
    localparam int EG  = 8;
    localparam int ET  = 4;
    localparam int EPM = 400;
    localparam int EPC = 800;
    localparam int ED  = 100;
    localparam int EE  = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [3:0]  req_cmd = 4'd0;
    logic [15:0] req_payload = 16'd0;
    logic        req_long = 1'b0;
    logic        pgc, pgd_out, pgd_oe;
    logic        pgd_in = 1'b0;
    logic        rsp_done;
    logic [7:0]  rsp_data;

    int tests = 0;
    int fails = 0;

    // monitor state
    bit          mon_active = 1'b0;
    logic        p_pgc = 1'b0, p_pgd = 1'b0, p_oe = 1'b1;
    int          busy_cyc, hi_run, lo_run, max_hi, min_hi, max_lo, nbits, oe_cnt, rx_idx;
    logic [63:0] bits;
    logic [7:0]  rx_byte;

    always #2.5 clk = ~clk;

    sps_host_seq #(
        .CLK_HZ(200_000_000), .HALF_NS(20), .GAP_NS(40), .TURN_NS(20),
        .PROG_MEM_NS(2000), .PROG_CFG_NS(4000), .DISCH_NS(500), .ERASE_NS(1500)
    ) u_sps_host_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_cmd(req_cmd), .req_payload(req_payload),
        .req_long(req_long), .pgc(pgc), .pgd_out(pgd_out), .pgd_oe(pgd_oe),
        .pgd_in(pgd_in), .rsp_done(rsp_done), .rsp_data(rsp_data)
    );

    always @(negedge clk) begin
        if (mon_active && !req_ready) begin
            busy_cyc++;
            if (pgc) begin
                hi_run++;
                lo_run = 0;
                if (hi_run > max_hi) max_hi = hi_run;
            end else begin
                if (p_pgc && hi_run < min_hi) min_hi = hi_run;
                lo_run++;
                hi_run = 0;
                if (lo_run > max_lo) max_lo = lo_run;
            end
            if (p_pgc && !pgc && p_oe) begin
                bits[nbits] = p_pgd;
                nbits++;
            end
            if (!pgd_oe) oe_cnt++;
            if (!p_pgc && pgc && !pgd_oe) begin
                pgd_in = rx_byte[rx_idx];
                rx_idx++;
            end
        end
        p_pgc = pgc;
        p_pgd = pgd_out;
        p_oe  = pgd_oe;
    end

    task automatic check(bit ok, string req, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_total(int k, bit l);
        case (k)
            0: return 40*EH + 2*EG;
            1: return 40*EH + ET + 2*EG;
            2: return 78*EH + 3*EG + (l ? EPC : EPM) + ED;
            default: return 79*EH + 3*EG + EE;
        endcase
    endfunction

    function automatic int exp_max_hi(int k, bit l);
        return (k == 2) ? (l ? EPC : EPM) : EH;
    endfunction

    function automatic int exp_max_lo(int k);
        return (k == 2) ? ED : (k == 3) ? EE : EH + EG;
    endfunction

    function automatic int exp_nbits(int k);
        return (k == 0) ? 20 : (k == 1) ? 12 : 40;
    endfunction

    function automatic logic [63:0] exp_bits(int k, logic [3:0] c, logic [15:0] p);
        if (k == 1) return {52'd0, p[7:0], c};
        return {44'd0, p, c};
    endfunction

    task automatic run_frame(int k, logic [3:0] c, logic [15:0] p, bit l, logic [7:0] rb);
        @(posedge clk); #1;
        req_kind = 2'(k); req_cmd = c; req_payload = p; req_long = l;
        rx_byte = rb;
        busy_cyc = 0; hi_run = 0; lo_run = 0; max_hi = 0; min_hi = 1 << 30;
        max_lo = 0; nbits = 0; oe_cnt = 0; rx_idx = 0; bits = '0;
        mon_active = 1'b1;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        do @(negedge clk); while (!rsp_done);
        mon_active = 1'b0;
        case (k)
            0: check(busy_cyc == exp_total(k, l), "R4 write length", busy_cyc, exp_total(k, l));
            1: check(busy_cyc == exp_total(k, l), "R5 read length", busy_cyc, exp_total(k, l));
            2: check(busy_cyc == exp_total(k, l), "R7 program length", busy_cyc, exp_total(k, l));
            default: check(busy_cyc == exp_total(k, l), "R8 erase length", busy_cyc, exp_total(k, l));
        endcase
        check(nbits == exp_nbits(k), "R2 bit count", nbits, exp_nbits(k));
        check(bits == exp_bits(k, c, p), "R2 bit order", bits, exp_bits(k, c, p));
        check(min_hi == EH, "R3 shortest high", min_hi, EH);
        if (k == 2)
            check(max_hi == exp_max_hi(k, l), "R7 hold high", max_hi, exp_max_hi(k, l));
        else
            check(max_hi == exp_max_hi(k, l), "R3 longest high", max_hi, exp_max_hi(k, l));
        if (k == 3)
            check(max_lo == exp_max_lo(k), "R8 erase wait", max_lo, exp_max_lo(k));
        else if (k == 2)
            check(max_lo == exp_max_lo(k), "R7 discharge", max_lo, exp_max_lo(k));
        else
            check(max_lo == exp_max_lo(k), "R4 gap low", max_lo, exp_max_lo(k));
        check(oe_cnt == ((k == 1) ? ET + 16*EH : 0), "R6 release cycles", oe_cnt,
              (k == 1) ? ET + 16*EH : 0);
        if (k == 1) check(rsp_data == rb, "R5 read byte", rsp_data, rb);
        check(req_ready == 1'b1, "R9 ready with done", req_ready, 1);
        @(negedge clk);
        check(rsp_done == 1'b0, "R9 done one cycle", rsp_done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1 reset state
        check(pgc == 1'b0, "R1 clock low", pgc, 0);
        check(pgd_out == 1'b0, "R1 data low", pgd_out, 0);
        check(pgd_oe == 1'b1, "R1 driving", pgd_oe, 1);
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(rsp_done == 1'b0, "R1 done low", rsp_done, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners
        run_frame(0, 4'hF, 16'hFFFF, 1'b0, 8'h00);
        run_frame(0, 4'h0, 16'h8001, 1'b0, 8'h00);
        run_frame(1, 4'h9, 16'h0000, 1'b0, 8'hA5);
        run_frame(1, 4'h2, 16'h00FF, 1'b0, 8'h80);
        run_frame(2, 4'hF, 16'h1234, 1'b0, 8'h00);
        run_frame(2, 4'hF, 16'h00C3, 1'b1, 8'h00);
        run_frame(3, 4'h0, 16'h0000, 1'b0, 8'h00);

        // random traffic
        for (int i = 0; i < 30; i++) begin
            run_frame(int'($urandom_range(0, 3)), 4'($urandom), 16'($urandom),
                      1'($urandom), 8'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule